// File: doc/BRIEF.md
# Haar Wavelet Perfect-Reconstruction Chain

This block takes a stream of signed fixed-point samples, organised into frames marked by a start strobe. It passes them through a one-level Haar analysis stage and then straight into the matching synthesis stage, and it returns each sample unchanged exactly three active cycles after it entered. The block proves perfect reconstruction in integer hardware. It sits in a test or loopback path, where any difference between input and output points to a fault in the filter bank.

The analysis stage pairs each even-position sample of a frame with the sample that follows it. It forms the sum (low-pass, approximation) and the difference (high-pass, detail) once per pair, so both branches are decimated by two. Pairing always starts at the frame's first sample, so only the frame-aligned polyphase is kept. This plays the part of the frame-level rotation and of the central-part trim: the border terms of the full convolution are never produced, and nothing has to be removed afterwards. The synthesis stage rebuilds the pair as half the sum and half the difference of the two branch words, using an arithmetic right shift. It emits the two results serially, which is the upsample-and-add step, and it restores the frame order on the way out.

A single clock enable paces the whole chain. The analysis registers load only on the enabled cycle that completes a pair, so the decimated section runs at half the sample rate without a second clock. A small state machine tracks the pair phase and the position in the frame. Its states are: IDLE (outside any frame), EVEN (the next sample opens a pair) and ODD (the next sample closes a pair). Its transitions are:
- START: from any state, an enabled cycle with the start strobe raised moves to ODD.
- PAIR_OPEN: EVEN moves to ODD on an enabled sample while the frame is not yet full.
- PAIR_CLOSE: ODD moves to EVEN on an enabled sample with no start strobe.
- FRAME_DONE: EVEN moves to IDLE on an enabled sample once the frame length has been reached.
- RESYNC: a START taken while in ODD, which orphans the held sample.

Top module: `haar_pr_chain`

## Requirements
- R1: During reset and on the first cycles after it, `out_data` is 0, `out_valid` is 0 and `out_start` is 0.
- R2: A sample accepted in enabled cycle k appears on `out_data`, bit-exact and with `out_valid` high, in the cycle after enabled cycle k+2. This holds across pairs and across frame boundaries, including back-to-back frames.
- R3: In a cycle with `ce` low, nothing changes: `out_data`, `out_valid` and `out_start` hold their values, and `frame_start` and `in_data` are ignored.
- R4: `out_start` is high, together with `out_valid`, exactly in the output slot of a sample that was accepted with `frame_start` high.
- R5: Pairing restarts at every accepted frame start. Position 0 of a frame pairs with position 1, position 2 with position 3, and so on. A start strobe that arrives while a pair is half open discards the held sample: that sample's output slot shows `out_valid`=0, `out_data`=0 and `out_start`=0.
- R6: Once FRAME_LEN samples of a frame have been accepted, further enabled samples without a start strobe are ignored. Their output slots show `out_valid`=0 and `out_data`=0.
- R7: The full input range, from -2^(DATA_W-1) to 2^(DATA_W-1)-1 and in any pair combination, is reconstructed without overflow. The output is clipped to the input width.
- R8: Whenever `out_valid` is low, `out_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Clock enable; one sample per enabled cycle |
| frame_start | input | 1 | Marks `in_data` as position 0 of a new frame |
| in_data | input | DATA_W | Signed input sample |
| out_data | output | DATA_W | Signed reconstructed sample |
| out_valid | output | 1 | `out_data` holds a reconstructed sample |
| out_start | output | 1 | `out_data` is position 0 of a frame |

## Verification
The bench builds the block with DATA_W=8 and FRAME_LEN=8. The narrow word lets the extreme codes -128 and 127 be driven in every pair combination. The short frame lets the FRAME_DONE transition into IDLE, back-to-back frames and an early RESYNC all be reached within a few dozen enabled cycles. Cycles with `ce` held low are interleaved with strobes and data changes, to show that they are ignored.

// File: rtl/haar_pr_pkg.sv
package haar_pr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVEN = 2'd1,
        ST_ODD  = 2'd2
    } hpr_state_e;

    localparam int unsigned HPR_LATENCY = 3;

endpackage

// File: rtl/haar_frame_ctrl.sv
module haar_frame_ctrl #(
    parameter int unsigned FRAME_LEN = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic frame_start,
    output logic take_even,
    output logic take_odd,
    output logic orphan,
    output logic start_acc
);
    import haar_pr_pkg::*;

    localparam int unsigned CNT_W = $clog2(FRAME_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_LEN);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    hpr_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // transitions and outputs
    always_comb begin
        st_d      = st_q;
        cnt_d     = cnt_q;
        take_even = 1'b0;
        take_odd  = 1'b0;
        orphan    = 1'b0;
        start_acc = 1'b0;
        if (ce) begin
            unique case (st_q)
                ST_IDLE: begin
                    if (frame_start) begin           // START
                        take_even = 1'b1;
                        start_acc = 1'b1;
                        cnt_d     = CNT_ONE;
                        st_d      = ST_ODD;
                    end
                end
                ST_EVEN: begin
                    if (frame_start) begin           // START
                        take_even = 1'b1;
                        start_acc = 1'b1;
                        cnt_d     = CNT_ONE;
                        st_d      = ST_ODD;
                    end else if (cnt_q == CNT_FULL) begin // FRAME_DONE
                        cnt_d = '0;
                        st_d  = ST_IDLE;
                    end else begin                   // PAIR_OPEN
                        take_even = 1'b1;
                        cnt_d     = cnt_q + CNT_ONE;
                        st_d      = ST_ODD;
                    end
                end
                ST_ODD: begin
                    if (frame_start) begin           // RESYNC
                        orphan    = 1'b1;
                        take_even = 1'b1;
                        start_acc = 1'b1;
                        cnt_d     = CNT_ONE;
                        st_d      = ST_ODD;
                    end else begin                   // PAIR_CLOSE
                        take_odd = 1'b1;
                        cnt_d    = cnt_q + CNT_ONE;
                        st_d     = ST_EVEN;
                    end
                end
                default: begin
                    cnt_d = '0;
                    st_d  = ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/haar_analysis.sv
module haar_analysis #(
    parameter int unsigned DATA_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ce,
    input  logic                     take_even,
    input  logic                     take_odd,
    input  logic signed [DATA_W-1:0] x,
    output logic signed [DATA_W:0]   approx,
    output logic signed [DATA_W:0]   detail,
    output logic                     pair_vld
);
    logic signed [DATA_W-1:0] hold_q;
    logic signed [DATA_W:0]   hold_x, x_x;

    assign hold_x = $signed({hold_q[DATA_W-1], hold_q});
    assign x_x    = $signed({x[DATA_W-1], x});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q   <= '0;
            approx   <= '0;
            detail   <= '0;
            pair_vld <= 1'b0;
        end else if (ce) begin
            pair_vld <= take_odd;
            if (take_even) begin
                hold_q <= x;
            end
            if (take_odd) begin
                approx <= hold_x + x_x;   // low-pass branch, decimated
                detail <= hold_x - x_x;   // high-pass branch, decimated
            end
        end
    end

endmodule

// File: rtl/haar_synthesis.sv
module haar_synthesis #(
    parameter int unsigned DATA_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ce,
    input  logic                     pair_vld,
    input  logic signed [DATA_W:0]   approx,
    input  logic signed [DATA_W:0]   detail,
    output logic signed [DATA_W-1:0] y
);
    localparam int unsigned EW = DATA_W + 2;
    localparam logic signed [EW-1:0] MAXV = {3'b000, {(DATA_W-1){1'b1}}};
    localparam logic signed [EW-1:0] MINV = {3'b111, {(DATA_W-1){1'b0}}};

    logic signed [EW-1:0]     a_x, d_x, sum_w, dif_w, ev_w, od_w;
    logic signed [DATA_W-1:0] odd_q;

    function automatic logic signed [DATA_W-1:0] clip(input logic signed [EW-1:0] v);
        if (v > MAXV)      return MAXV[DATA_W-1:0];
        else if (v < MINV) return MINV[DATA_W-1:0];
        else               return v[DATA_W-1:0];
    endfunction

    always_comb begin
        a_x   = $signed({approx[DATA_W], approx});
        d_x   = $signed({detail[DATA_W], detail});
        sum_w = a_x + d_x;
        dif_w = a_x - d_x;
        ev_w  = sum_w >>> 1;
        od_w  = dif_w >>> 1;
    end

    // upsample and add: even result first, odd result on the next enabled cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y     <= '0;
            odd_q <= '0;
        end else if (ce) begin
            if (pair_vld) begin
                y     <= clip(ev_w);
                odd_q <= clip(od_w);
            end else begin
                y     <= odd_q;
                odd_q <= '0;
            end
        end
    end

endmodule

// File: rtl/haar_pr_chain.sv
module haar_pr_chain #(
    parameter int unsigned DATA_W    = 12,
    parameter int unsigned FRAME_LEN = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ce,
    input  logic                     frame_start,
    input  logic signed [DATA_W-1:0] in_data,
    output logic signed [DATA_W-1:0] out_data,
    output logic                     out_valid,
    output logic                     out_start
);
    import haar_pr_pkg::*;

    localparam int unsigned DEPTH = HPR_LATENCY;

    logic                   take_even, take_odd, orphan, start_acc;
    logic signed [DATA_W:0] approx, detail;
    logic                   pair_vld;
    logic [DEPTH-1:0]       vld_q, sta_q;

    haar_frame_ctrl #(.FRAME_LEN(FRAME_LEN)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce         (ce),
        .frame_start(frame_start),
        .take_even  (take_even),
        .take_odd   (take_odd),
        .orphan     (orphan),
        .start_acc  (start_acc)
    );

    haar_analysis #(.DATA_W(DATA_W)) u_ana (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce       (ce),
        .take_even(take_even),
        .take_odd (take_odd),
        .x        (in_data),
        .approx   (approx),
        .detail   (detail),
        .pair_vld (pair_vld)
    );

    haar_synthesis #(.DATA_W(DATA_W)) u_syn (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce      (ce),
        .pair_vld(pair_vld),
        .approx  (approx),
        .detail  (detail),
        .y       (out_data)
    );

    // sideband delay line; stage 1 drops an orphaned sample's markers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            sta_q <= '0;
        end else if (ce) begin
            vld_q[0] <= take_even | take_odd;
            sta_q[0] <= start_acc;
            vld_q[1] <= vld_q[0] & ~orphan;
            sta_q[1] <= sta_q[0] & ~orphan;
        end
    end

    for (genvar g = 2; g < DEPTH; g++) begin : g_tail
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q[g] <= 1'b0;
                sta_q[g] <= 1'b0;
            end else if (ce) begin
                vld_q[g] <= vld_q[g-1];
                sta_q[g] <= sta_q[g-1];
            end
        end
    end

    assign out_valid = vld_q[DEPTH-1];
    assign out_start = sta_q[DEPTH-1];

endmodule

// File: rtl/haar_pr_chain_chk.sv
module haar_pr_chain_chk #(
    parameter int unsigned DATA_W = 12
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     ce,
    input logic                     frame_start,
    input logic signed [DATA_W-1:0] in_data,
    input logic signed [DATA_W-1:0] out_data,
    input logic                     out_valid,
    input logic                     out_start
);
    logic signed [DATA_W-1:0] m0, m1, m2;
    logic                     f0, f1, f2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m0 <= '0; m1 <= '0; m2 <= '0;
            f0 <= 1'b0; f1 <= 1'b0; f2 <= 1'b0;
        end else if (ce) begin
            m0 <= in_data; m1 <= m0; m2 <= m1;
            f0 <= frame_start; f1 <= f0; f2 <= f1;
        end
    end

    // R2: a valid output equals the input from three enabled cycles before
    p_delay3_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data == m2));

    // R3: an idle enable freezes every output
    p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> ($stable(out_data) && $stable(out_valid) && $stable(out_start)));

    // R4: a start marker only accompanies valid data
    p_start_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_start |-> out_valid);

    // R4: a start marker traces back to a strobe three enabled cycles before
    p_start_origin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_start |-> f2);

    // R8: invalid slots carry zero data
    p_quiet_invalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_data == '0));

endmodule

bind haar_pr_chain haar_pr_chain_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce         (ce),
    .frame_start(frame_start),
    .in_data    (in_data),
    .out_data   (out_data),
    .out_valid  (out_valid),
    .out_start  (out_start)
);

// File: tb/tb_haar_pr_chain.sv
module tb_haar_pr_chain;
    localparam int DW = 8;
    localparam int FL = 8;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 ce = 1'b0;
    logic                 frame_start = 1'b0;
    logic signed [DW-1:0] in_data = '0;
    logic signed [DW-1:0] out_data;
    logic                 out_valid;
    logic                 out_start;

    int total = 0;
    int bad = 0;
    int n = 0;
    int pos = 0;
    bit in_frame = 0;
    bit done = 0;

    logic                 hv [0:4095];
    logic                 hs [0:4095];
    logic signed [DW-1:0] hd [0:4095];

    always #5 clk = ~clk;

    haar_pr_chain #(.DATA_W(DW), .FRAME_LEN(FL)) dut (
        .clk(clk), .rst_n(rst_n), .ce(ce), .frame_start(frame_start),
        .in_data(in_data), .out_data(out_data), .out_valid(out_valid),
        .out_start(out_start)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d (slot %0d)", req, what, act, exp, n);
        end
    endtask

    // one cycle: drive at the falling edge, observe at the next falling edge
    task automatic step(input logic c, input logic f, input int x, input string req);
        logic pv, ps;
        logic signed [DW-1:0] pd;
        bit acc, st;
        pv = out_valid; pd = out_data; ps = out_start;
        ce = c; frame_start = f; in_data = DW'(x);
        @(negedge clk);
        if (c) begin
            acc = 0; st = 0;
            if (f) begin
                if (in_frame && (pos % 2 == 1) && n > 0) begin   // R5 orphan
                    hv[n-1] = 0; hd[n-1] = '0; hs[n-1] = 0;
                end
                acc = 1; st = 1; pos = 1; in_frame = 1;
            end else if (in_frame && pos < FL) begin
                acc = 1; pos++;
            end else begin
                in_frame = 0;                                    // R6 ignored
            end
            hv[n] = acc; hs[n] = st; hd[n] = acc ? DW'(x) : '0;
            if (n >= 2) begin
                chk(req, "valid", int'(out_valid), int'(hv[n-2]));
                chk(req, "data",  int'(out_data),  int'(hd[n-2]));
                chk(req, "start", int'(out_start), int'(hs[n-2]));
            end else begin
                chk("R1", "valid", int'(out_valid), 0);
                chk("R1", "data",  int'(out_data),  0);
            end
            n++;
        end else begin
            chk("R3", "held valid", int'(out_valid), int'(pv));
            chk("R3", "held data",  int'(out_data),  int'(pd));
            chk("R3", "held start", int'(out_start), int'(ps));
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "valid in reset", int'(out_valid), 0);
        chk("R1", "data in reset",  int'(out_data),  0);
        chk("R1", "start in reset", int'(out_start), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "valid after reset", int'(out_valid), 0);
        chk("R1", "start after reset", int'(out_start), 0);
    endtask

    task automatic t_ramp();       // R2, R8
        for (int i = 0; i < FL; i++) step(1, i == 0, 3 * i - 10, "R2");
        for (int i = 0; i < 4; i++) step(1, 0, 99, "R8");
    endtask

    task automatic t_back_to_back();   // R2, R4
        for (int i = 0; i < 2 * FL; i++) step(1, (i % FL) == 0, (i * 37) % 200 - 100, "R4");
        for (int i = 0; i < 3; i++) step(1, 0, 5, "R2");
    endtask

    task automatic t_ce_gaps();    // R3
        for (int i = 0; i < FL; i++) begin
            step(1, i == 0, 50 - 11 * i, "R3");
            step(0, 1, -77, "R3");
            step(0, 0, 13, "R3");
        end
        for (int i = 0; i < 3; i++) step(1, 0, 0, "R3");
    endtask

    task automatic t_orphan();     // R5
        step(1, 1, 21, "R5");
        step(1, 0, 22, "R5");
        step(1, 0, 23, "R5");
        step(1, 1, 40, "R5");      // strobe at odd position: 23 is dropped
        step(1, 1, 41, "R5");      // again: 40 is dropped
        for (int i = 0; i < FL - 1; i++) step(1, 0, -i, "R5");
        for (int i = 0; i < 3; i++) step(1, 0, 0, "R5");
    endtask

    task automatic t_frame_end();  // R6
        for (int i = 0; i < FL + 4; i++) step(1, i == 0, 60 + i, "R6");
        step(1, 0, -1, "R6");
        step(1, 0, -2, "R6");
    endtask

    task automatic t_extremes();   // R7
        int v [8] = '{127, -128, -128, 127, 127, 127, -128, -128};
        for (int i = 0; i < 8; i++) step(1, i == 0, v[i], "R7");
        for (int i = 0; i < 3; i++) step(1, 0, 0, "R7");
    endtask

    initial begin
        t_reset();
        t_ramp();
        t_back_to_back();
        t_ce_gaps();
        t_orphan();
        t_frame_end();
        t_extremes();
        ce = 1'b0;
        frame_start = 1'b0;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule